// File: doc/BRIEF.md
# Frame-Gated Control Register

The block holds a control word made of 8-bit bytes that a host writes one byte at a time. Host writes land in a pending copy. The pending copy becomes the active control word only on a frame strobe, so the core sees a consistent set of settings for each whole frame. The active word drives the core through `ctrl_o`.

Most bits may change only while the device is settled in its neutral operating mode. A mode field sits in byte 0. A dwell counter tracks how many frame strobes in a row have applied a neutral mode. A host write that would alter a gated bit is refused unless the pending mode is neutral and the dwell count has reached its minimum. A refused write sets a sticky error flag. A per-bit mask names the on-the-fly bits, which may be rewritten at any time; the mode field itself is among them.

Reset leaves the mode neutral and the dwell counter full, so the host can write immediately. The status word has the same layout as the control word. It reports the active control word as it stood a fixed number of frames earlier, which models the internal processing pipeline.

Top module: `frame_gated_ctrl`

## Requirements
- R1: After reset, `ctrl_o` and `status_o` are 0, `err_o` is 0, and a write to a gated bit is accepted at once without waiting for any frame strobe.
- R2: A host write to byte `a` changes only pending byte `a`. `ctrl_o` keeps its value until the next `frame_i` strobe, and it takes the pending word in the cycle after that strobe's clock edge.
- R3: Bits set in `OTF_MASK` may be written at any time, including while the mode is not neutral, and are applied at the next strobe. The default mask is 0x0000F003: the mode field (byte 0 bits 1:0) and byte 1 bits 7:4.
- R4: A write that changes any bit outside `OTF_MASK` relative to the pending byte is refused as a whole unless two conditions hold: the pending mode is neutral (2'b00), and the dwell count is at least `DWELL_FRAMES` (3). A refused write leaves every bit of that byte unchanged, including its on-the-fly bits.
- R5: A refused write sets `err_o` in the following cycle. `err_o` then stays at 1 until reset.
- R6: A strobe that applies a non-neutral mode clears the dwell count. After neutral is applied again, gated writes stay refused until three strobes have applied neutral in a row.
- R7: `status_o` changes only on strobes. After strobe k, it shows the control word that strobe k-3 made active, or 0 if there has been no such strobe since reset.
- R8: A write that rewrites the gated bits with their current pending values and changes only on-the-fly bits is accepted in any mode and dwell state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Host byte write strobe |
| wr_addr_i | input | AW (2) | Byte index within the control word |
| wr_data_i | input | 8 | Byte to write |
| frame_i | input | 1 | One-cycle frame boundary strobe |
| ctrl_o | output | 8*NUM_BYTES (32) | Active control word |
| status_o | output | 8*NUM_BYTES (32) | Control word delayed by STATUS_LAT frames |
| err_o | output | 1 | Sticky refused-write flag |

## Verification
The pending copy is written at the write's clock edge. `ctrl_o` changes at the strobe's edge, and `err_o` rises at the edge of the refused write. Each result therefore appears one cycle after its stimulus. The bench drives inputs on falling edges and samples on the next falling edge, half a cycle after the edge that updates the result. Status lag is counted in strobes rather than cycles: the bench checks `status_o` after two strobes, where it must still hold the old value, and after the third, where it must hold the new one. Refused writes are observed at the ports by issuing a strobe and comparing `ctrl_o` with the bench's own model of the pending word.

// File: rtl/fgc_pkg.sv
package fgc_pkg;
  typedef logic [7:0] fgc_byte_t;
  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/fgc_shadow.sv
module fgc_shadow
  import fgc_pkg::*;
#(
  parameter int unsigned NUM_BYTES = 4,
  parameter int unsigned AW = 2,
  parameter logic [8*NUM_BYTES-1:0] OTF_MASK = '0,
  localparam int unsigned W = BYTE_W * NUM_BYTES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  fgc_byte_t     wr_data_i,
  input  logic          gate_open_i,
  output logic [W-1:0]  shadow_o,
  output logic          err_o
);
  logic [W-1:0]         shadow_q;
  logic [NUM_BYTES-1:0] sel;
  fgc_byte_t            cur_byte, otf_byte;
  logic                 gated_diff, reject, accept;

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_sel
    assign sel[i] = wr_en_i && (wr_addr_i == AW'(i));
  end

  always_comb begin
    cur_byte = '0;
    otf_byte = '0;
    for (int i = 0; i < NUM_BYTES; i++) begin
      if (sel[i]) begin
        cur_byte = shadow_q[i*BYTE_W +: BYTE_W];
        otf_byte = OTF_MASK[i*BYTE_W +: BYTE_W];
      end
    end
  end

  assign gated_diff = |((wr_data_i ^ cur_byte) & ~otf_byte);
  assign reject     = (|sel) && gated_diff && !gate_open_i;
  assign accept     = (|sel) && !reject;

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                shadow_q[i*BYTE_W +: BYTE_W] <= '0;
      else if (accept && sel[i])  shadow_q[i*BYTE_W +: BYTE_W] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     err_o <= 1'b0;
    else if (reject) err_o <= 1'b1;
  end

  assign shadow_o = shadow_q;

  AST_REJECT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject |=> $stable(shadow_q)); // R4
  AST_ERR_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject |=> err_o); // R5
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R5
endmodule

// File: rtl/fgc_dwell.sv
module fgc_dwell #(
  parameter int unsigned DWELL_FRAMES = 3,
  localparam int unsigned CW = $clog2(DWELL_FRAMES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_i,
  input  logic next_neutral_i,
  output logic open_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= CW'(DWELL_FRAMES);  // neutral after reset
    else if (frame_i) begin
      if (!next_neutral_i)                  cnt_q <= '0;
      else if (cnt_q != CW'(DWELL_FRAMES))  cnt_q <= cnt_q + 1'b1;
    end
  end

  assign open_o = (cnt_q == CW'(DWELL_FRAMES));

  AST_DWELL_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_i && !next_neutral_i) |=> !open_o); // R6
  AST_DWELL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DWELL_FRAMES)); // R6
  AST_DWELL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/fgc_status_pipe.sv
module fgc_status_pipe #(
  parameter int unsigned W = 32,
  parameter int unsigned LAT = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         frame_i,
  input  logic [W-1:0] ctrl_i,
  output logic [W-1:0] status_o
);
  logic [W-1:0] stage_q [LAT];

  for (genvar s = 0; s < LAT; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      stage_q[s] <= '0;
      else if (frame_i) stage_q[s] <= (s == 0) ? ctrl_i : stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign status_o = stage_q[LAT-1];

  AST_STATUS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(status_o)); // R7
endmodule

// File: rtl/frame_gated_ctrl.sv
module frame_gated_ctrl
  import fgc_pkg::*;
#(
  parameter int unsigned NUM_BYTES    = 4,
  parameter int unsigned DWELL_FRAMES = 3,
  parameter int unsigned STATUS_LAT   = 3,
  parameter int unsigned MODE_LSB     = 0,
  parameter int unsigned MODE_W       = 2,
  parameter logic [MODE_W-1:0] MODE_NEUTRAL = '0,
  parameter logic [8*NUM_BYTES-1:0] OTF_MASK = 32'h0000_F003,
  parameter int unsigned AW = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [AW-1:0]         wr_addr_i,
  input  logic [7:0]            wr_data_i,
  input  logic                  frame_i,
  output logic [8*NUM_BYTES-1:0] ctrl_o,
  output logic [8*NUM_BYTES-1:0] status_o,
  output logic                  err_o
);
  localparam int unsigned W = BYTE_W * NUM_BYTES;

  logic [W-1:0] shadow, ctrl_q;
  logic         pend_neutral, dwell_open;

  assign pend_neutral = (shadow[MODE_LSB +: MODE_W] == MODE_NEUTRAL);

  fgc_shadow #(.NUM_BYTES(NUM_BYTES), .AW(AW), .OTF_MASK(OTF_MASK)) i_shadow (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .gate_open_i (dwell_open && pend_neutral),
    .shadow_o    (shadow),
    .err_o
  );

  fgc_dwell #(.DWELL_FRAMES(DWELL_FRAMES)) i_dwell (
    .clk_i, .rst_ni, .frame_i,
    .next_neutral_i (pend_neutral),
    .open_o         (dwell_open)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (frame_i) ctrl_q <= shadow;
  end

  fgc_status_pipe #(.W(W), .LAT(STATUS_LAT)) i_status (
    .clk_i, .rst_ni, .frame_i,
    .ctrl_i   (ctrl_q),
    .status_o
  );

  assign ctrl_o = ctrl_q;

  AST_CTRL_FRAME_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(ctrl_o)); // R2
  AST_CTRL_TAKES_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |=> (ctrl_o == $past(shadow))); // R2
endmodule

// File: tb/test_frame_gated_ctrl.sv
module test_frame_gated_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        frame = 1'b0;
  logic [31:0] ctrl, status;
  logic        err;
  int          n_chk = 0, n_fail = 0;
  logic [31:0] exp_ctrl = '0;

  always #5 clk = ~clk;

  frame_gated_ctrl i_frame_gated_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .frame_i(frame), .ctrl_o(ctrl), .status_o(status), .err_o(err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk); frame = 1'b1;
    @(negedge clk); frame = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; exp_ctrl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 ctrl", ctrl, 32'h0);
    check("R1 status", status, 32'h0);
    check("R1 err", {31'b0, err}, 32'h0);
  endtask

  task automatic t_write_apply();
    wr(2'd2, 8'hA5);                 // gated byte, dwell full after reset
    check("R2 ctrl held before strobe", ctrl, 32'h0);
    check("R1 no error on early write", {31'b0, err}, 32'h0);
    strobe();
    exp_ctrl = 32'h00A5_0000;
    check("R2 applied on strobe", ctrl, exp_ctrl);
    check("R1 err still clear", {31'b0, err}, 32'h0);
  endtask

  task automatic t_status_lag();
    strobe(); strobe();
    check("R7 status after two strobes", status, 32'h0);
    wr(2'd1, 8'h10);
    exp_ctrl = 32'h00A5_1000;
    check("R7 status stable between strobes", status, 32'h0);
    strobe();                        // third strobe after A5 applied; also applies 10
    check("R7 status after three strobes", status, 32'h00A5_0000);
    strobe(); strobe();
    check("R7 status one short", status, 32'h00A5_0000);
    strobe();
    check("R7 status shows later word", status, exp_ctrl);
  endtask

  task automatic t_mode_gate();
    wr(2'd0, 8'h01);                 // non-neutral mode, on-the-fly bits
    strobe();
    exp_ctrl = 32'h00A5_1001;
    check("R3 mode applied", ctrl, exp_ctrl);
    wr(2'd2, 8'h5A);
    check("R5 err set on refusal", {31'b0, err}, 32'h1);
    strobe();
    check("R4 gated byte refused", ctrl, exp_ctrl);
    wr(2'd1, 8'hF0);                 // changes upper nibble only vs pending 0x10? lower nibble 0 both
    strobe();
    exp_ctrl = 32'h00A5_F001;
    check("R3 on-the-fly nibble applied", ctrl, exp_ctrl);
    wr(2'd1, 8'h71);                 // on-the-fly + gated change: refused as a whole
    strobe();
    check("R4 whole byte refused", ctrl, exp_ctrl);
    wr(2'd1, 8'h30);                 // gated bits unchanged
    strobe();
    exp_ctrl = 32'h00A5_3001;
    check("R8 same gated values accepted", ctrl, exp_ctrl);
  endtask

  task automatic t_dwell();
    wr(2'd0, 8'h00);                 // back to neutral
    strobe();                        // dwell 1
    exp_ctrl = 32'h00A5_3000;
    check("R6 neutral applied", ctrl, exp_ctrl);
    wr(2'd2, 8'h5A);
    strobe();                        // dwell 2
    check("R6 refused at dwell 1", ctrl, exp_ctrl);
    wr(2'd2, 8'h5A);
    strobe();                        // dwell 3
    check("R6 refused at dwell 2", ctrl, exp_ctrl);
    wr(2'd2, 8'h5A);
    strobe();
    exp_ctrl = 32'h005A_3000;
    check("R6 accepted at dwell 3", ctrl, exp_ctrl);
    check("R5 err sticky", {31'b0, err}, 32'h1);
    do_reset();
    check("R5 err cleared by reset", {31'b0, err}, 32'h0);
    check("R1 ctrl after second reset", ctrl, 32'h0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_write_apply();
    t_status_lag();
    t_mode_gate();
    t_dwell();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule